// File: doc/BRIEF.md
# Fractional-N Feedback Divider Calculator

This block turns a reference clock frequency, given as an integer number of hertz, into the feedback divider settings of a fractional-N PLL whose VCO must run at 2880 MHz. The loop relation is f_vco = 2 * f_ref * (N + F / 65536). N is the integer part and F is a 16-bit fraction. The block derives both values with a single long division and packs them into a 32-bit configuration word. That word also carries fixed control bits, and its fractional-enable bit depends on whether F is zero.

A caller raises `start_i` for one cycle with `fin_hz_i` valid. If the frequency is outside the supported band, the block answers in the next cycle with `done_o` and `err_o` high and an all-zero word. Otherwise it runs a restoring shift-subtract divider that produces one quotient bit per clock, then pulses `done_o` with the word on `cfg_o`. While it is working, `busy_o` is high and further start requests are dropped.

Top module: `pll_div_calc`

## Requirements
- R1: A start request with `fin_hz_i` below 19,200,000 or above 38,400,000 gives `done_o`=1, `err_o`=1 and `cfg_o`=0 after the very edge that sampled it. Both bounds themselves count as valid. A valid result clears `err_o`.
- R2: On a valid result, `cfg_o[6:0]` equals floor(2,880,000,000 / (2*f)), truncated to 7 bits.
- R3: On a valid result, `cfg_o[25:10]` equals floor(2,880,000,000*65536 / (2*f)) - N*65536, which is the 16-bit fraction F.
- R4: Every valid result has `cfg_o[31]`, `cfg_o[30]` (the two dither-off controls) and `cfg_o[28]` (the strobe bypass) set to 1.
- R5: `cfg_o[29]` (the fractional-mode enable) is 1 exactly when F is nonzero. When F is zero, bits 29 and 25:10 are all 0.
- R6: Bits 27:26 and 9:7 of a valid word are 0.
- R7: For an in-range start sampled at edge E, `busy_o` is 1 from edge E through edge E+64. The one-cycle `done_o` pulse and the word appear after edge E+65.
- R8: A start raised while `busy_o` is 1 is ignored. It produces no extra `done_o` and does not change the result of the running computation.
- R9: `cfg_o` and `err_o` keep the last result until the next `done_o`.
- R10: After reset, `busy_o`, `done_o`, `err_o` and `cfg_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to compute a word |
| fin_hz_i | input | 32 | Reference frequency in Hz, sampled with the request |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Last result was an out-of-band frequency |
| cfg_o | output | 32 | Last PLL configuration word |

## Verification
Two events can share a cycle. The first is the end of a division, when `done_o` appears. The second is a new request, either on the last busy cycle or on the `done_o` cycle itself. The bench raises a start on the final busy cycle and expects it to be dropped, with no extra strobe and an unchanged word. In the very cycle `done_o` is seen, it issues an out-of-band request and then an in-range one. Both must be accepted, because `busy_o` has already fallen. The scoreboard then expects an error strobe one edge later, followed by a full-latency result.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  localparam int unsigned FIN_W  = 32;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned NDIV_W = 7;
  localparam int unsigned FRAC_W = 16;
  localparam int unsigned DIV_W  = 64;

  localparam logic [FIN_W-1:0] FIN_MIN = 32'd19_200_000;
  localparam logic [FIN_W-1:0] FIN_MAX = 32'd38_400_000;
  localparam logic [DIV_W-1:0] VCO_HZ  = 64'd2_880_000_000;
  // VCO target pre-scaled by 2^FRAC_W so one quotient holds N and F
  localparam logic [DIV_W-1:0] DIVIDEND = VCO_HZ << FRAC_W;

  // word bit positions that a downstream PLL decodes
  localparam int unsigned POS_DITH_B = 31;
  localparam int unsigned POS_DITH_A = 30;
  localparam int unsigned POS_FRACEN = 29;
  localparam int unsigned POS_SBYP   = 28;
  localparam int unsigned POS_FRAC   = 10;
  localparam int unsigned POS_NDIV   = 0;

  function automatic logic fin_in_band(input logic [FIN_W-1:0] f);
    return (f >= FIN_MIN) && (f <= FIN_MAX);
  endfunction

  function automatic logic [CFG_W-1:0] build_word(input logic [NDIV_W-1:0] n,
                                                  input logic [FRAC_W-1:0] fr);
    logic [CFG_W-1:0] w;
    w = '0;
    w[POS_DITH_B] = 1'b1;
    w[POS_DITH_A] = 1'b1;
    w[POS_SBYP]   = 1'b1;
    w[POS_NDIV +: NDIV_W] = n;
    if (fr != '0) begin
      w[POS_FRACEN] = 1'b1;
      w[POS_FRAC +: FRAC_W] = fr;
    end
    return w;
  endfunction
endpackage

// File: rtl/pll_range_chk.sv
module pll_range_chk
  import pll_calc_pkg::*;
#(
  parameter int unsigned W = FIN_W
) (
  input  logic [W-1:0] fin_i,
  output logic         ok_o
);
  always_comb ok_o = fin_in_band(fin_i);
endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int unsigned DW  = 64,
  parameter int unsigned VW  = 33,
  parameter int unsigned QW  = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          fin_o,
  output logic [QW-1:0] quot_o
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] rem_q, quo_q, dvs_q;
  logic [DW-1:0] rem_sh, rem_nx, quo_nx;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q, take;

  // one restoring step: shift in the next dividend bit, subtract if it fits
  always_comb begin
    rem_sh = {rem_q[DW-2:0], quo_q[DW-1]};
    take   = (rem_sh >= dvs_q);
    rem_nx = take ? (rem_sh - dvs_q) : rem_sh;
    quo_nx = {quo_q[DW-2:0], take};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= {{(DW-VW){1'b0}}, divisor_i};
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin_o  = fin_q;
  assign quot_o = quo_q[QW-1:0];
endmodule

// File: rtl/pll_cfg_pack.sv
module pll_cfg_pack
  import pll_calc_pkg::*;
#(
  parameter int unsigned NW = NDIV_W,
  parameter int unsigned FW = FRAC_W
) (
  input  logic [NW+FW-1:0] quot_i,
  output logic [CFG_W-1:0] cfg_o
);
  // the quotient's low FW bits are F, the next NW bits are N (truncated)
  always_comb cfg_o = build_word(quot_i[FW +: NW], quot_i[FW-1:0]);
endmodule

// File: rtl/pll_div_calc.sv
module pll_div_calc
  import pll_calc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [FIN_W-1:0] fin_hz_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int unsigned VW = FIN_W + 1;
  localparam int unsigned QW = NDIV_W + FRAC_W;

  logic             busy_q, done_q, err_q;
  logic [CFG_W-1:0] cfg_q;

  // named internal events
  logic             in_rng_w, accept_w, div_ld_w, reject_w, div_fin_w;
  logic [QW-1:0]    quot_w;
  logic [CFG_W-1:0] word_w;

  pll_range_chk #(.W(FIN_W)) u_rng (
    .fin_i (fin_hz_i),
    .ok_o  (in_rng_w)
  );

  assign accept_w = start_i & ~busy_q;
  assign div_ld_w = accept_w & in_rng_w;
  assign reject_w = accept_w & ~in_rng_w;

  pll_seq_div #(.DW(DIV_W), .VW(VW), .QW(QW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (div_ld_w),
    .dividend_i (DIVIDEND),
    .divisor_i  ({fin_hz_i, 1'b0}),
    .fin_o      (div_fin_w),
    .quot_o     (quot_w)
  );

  pll_cfg_pack #(.NW(NDIV_W), .FW(FRAC_W)) u_pack (
    .quot_i (quot_w),
    .cfg_o  (word_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cfg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (reject_w) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
        cfg_q  <= '0;
      end else if (div_ld_w) begin
        busy_q <= 1'b1;
      end
      if (div_fin_w) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= 1'b0;
        cfg_q  <= word_w;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/pll_div_calc_chk.sv
module pll_div_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] cfg_o,
  input logic        in_rng_w,
  input logic        div_fin_w
);
  // R1
  reject_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !in_rng_w) |=> (done_o && err_o && cfg_o == 32'h0));

  // R4
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (cfg_o[31] && cfg_o[30] && cfg_o[28]));

  // R5
  frac_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (cfg_o[29] == (cfg_o[25:10] != 16'h0)));

  // R6
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (cfg_o[27:26] == 2'b00 && cfg_o[9:7] == 3'b000));

  // R7
  finish_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin_w |=> (done_o && !err_o && !busy_o));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !div_fin_w) |=> busy_o);

  // R8
  no_done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(cfg_o) && $stable(err_o)));
endmodule

bind pll_div_calc pll_div_calc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .cfg_o     (cfg_o),
  .in_rng_w  (in_rng_w),
  .div_fin_w (div_fin_w)
);

// File: tb/tb_pll_div_calc.sv
module tb_pll_div_calc;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_OK     = 65;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] fin_hz_i = '0;
  logic        busy_o, done_o, err_o;
  logic [31:0] cfg_o;

  pll_div_calc dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .fin_hz_i (fin_hz_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .cfg_o    (cfg_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [31:0] word;
    logic        err;
    logic [31:0] cyc;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] last_cfg = '0;
  logic        last_err = 1'b0;
  bit          ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // independent model: N and remainder of (f_vco/2)/f, then scale remainder
  function automatic logic [31:0] model(input logic [31:0] f, output logic bad);
    longint unsigned n, r, fr;
    logic [15:0] f16;
    if (f < 32'd19_200_000 || f > 32'd38_400_000) begin
      bad = 1'b1;
      return 32'h0;
    end
    bad = 1'b0;
    n   = 64'd1_440_000_000 / f;
    r   = 64'd1_440_000_000 % f;
    fr  = (r * 64'd65536) / f;
    f16 = fr[15:0];
    return {1'b1, 1'b1, (f16 != 16'h0), 1'b1, 2'b00, f16, 3'b000, n[6:0]};
  endfunction

  // driver: request in the current (negedge) slot, push the expectation
  task automatic send_now(input logic [31:0] f);
    exp_t e;
    logic bad;
    e.word = model(f, bad);
    e.err  = bad;
    e.cyc  = 32'(cyc + 1 + (bad ? 0 : LAT_OK));
    sb.push_back(e);
    start_i  = 1'b1;
    fin_hz_i = f;
    @(negedge clk);
    start_i = 1'b0;
    if (!bad) check(busy_o == 1'b1, "R7 busy after start", 64'(busy_o), 64'd1);
  endtask

  task automatic send(input logic [31:0] f);
    @(negedge clk);
    send_now(f);
  endtask

  task automatic wait_idle();
    while (busy_o || sb.size() != 0) @(negedge clk);
  endtask

  // monitor: pop and compare each result strobe
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected done", 64'(cfg_o), 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(err_o == e.err, "R1 error flag", 64'(err_o), 64'(e.err));
        if (e.err) begin
          check(cfg_o == 32'h0, "R1 word on error", 64'(cfg_o), 64'h0);
          check(cyc == int'(e.cyc), "R1 error latency", 64'(cyc), 64'(e.cyc));
        end else begin
          check(cfg_o[6:0] == e.word[6:0], "R2 integer field",
                64'(cfg_o[6:0]), 64'(e.word[6:0]));
          check(cfg_o[25:10] == e.word[25:10], "R3 fraction field",
                64'(cfg_o[25:10]), 64'(e.word[25:10]));
          check(cfg_o[31] && cfg_o[30] && cfg_o[28], "R4 fixed controls",
                64'(cfg_o), 64'(e.word));
          check(cfg_o[29] == e.word[29], "R5 fractional enable",
                64'(cfg_o[29]), 64'(e.word[29]));
          check(cfg_o[27:26] == 2'b00 && cfg_o[9:7] == 3'b000, "R6 zero bits",
                64'(cfg_o), 64'(e.word));
          check(cyc == int'(e.cyc), "R7 result latency", 64'(cyc), 64'(e.cyc));
        end
        last_cfg <= cfg_o;
        last_err <= err_o;
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > WD_LIMIT && !ended) begin
      check(1'b0, "watchdog", 64'(cyc), 64'(WD_LIMIT));
      report();
    end
  end

  task automatic hold_check();
    repeat (10) @(negedge clk);
    check(cfg_o == last_cfg, "R9 word held", 64'(cfg_o), 64'(last_cfg));
    check(err_o == last_err, "R9 flag held", 64'(err_o), 64'(last_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    check(!busy_o && !done_o && !err_o && cfg_o == 32'h0, "R10 reset state",
          {29'h0, busy_o, done_o, err_o, cfg_o}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !done_o && cfg_o == 32'h0, "R10 idle after reset",
          {30'h0, busy_o, done_o, cfg_o}, 64'h0);

    // band edges and typical references (R2, R3, R5)
    send(32'd24_000_000); wait_idle();   // 0xD000003C, integer ratio
    send(32'd19_200_000); wait_idle();   // lower bound, 0xD000004B
    send(32'd38_400_000); wait_idle();   // upper bound, 0xF2000025
    send(32'd25_000_000); wait_idle();   // N=57, F=0x9999
    send(32'd26_000_000); wait_idle();
    send(32'd30_000_000); wait_idle();
    hold_check();

    // out-of-band requests (R1)
    send(32'd19_199_999); wait_idle();
    hold_check();
    send(32'd38_400_001); wait_idle();
    send(32'd0);          wait_idle();
    send(32'hFFFF_FFFF);  wait_idle();
    send(32'd27_000_000); wait_idle();
    check(err_o == 1'b0, "R1 error cleared by valid result", 64'(err_o), 64'd0);

    // R8: requests during a division, including its last busy cycle
    send(32'd32_000_000);
    repeat (5) @(negedge clk);
    start_i = 1'b1; fin_hz_i = 32'd0;
    @(negedge clk);
    start_i = 1'b1; fin_hz_i = 32'd20_000_000;
    @(negedge clk);
    start_i = 1'b0;
    while (cyc != int'(sb[0].cyc) - 1) @(negedge clk);
    check(busy_o == 1'b1, "R8 last busy cycle", 64'(busy_o), 64'd1);
    start_i = 1'b1; fin_hz_i = 32'd5;
    @(negedge clk);
    start_i = 1'b0;
    // done is visible now: back-to-back requests in the same slot
    check(done_o == 1'b1, "R7 done on expected slot", 64'(done_o), 64'd1);
    send_now(32'd12_000_000);
    send_now(32'd36_000_000);
    wait_idle();
    hold_check();

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R7 all results delivered", 64'(sb.size()), 64'd0);
    report();
  end
endmodule